// File: doc/BRIEF.md
# Motor Driver Fault and Sleep Supervisor

This block is the central protection and power-state controller of a dual-motor bridge driver. It takes the per-transistor current-limit flags, an over-temperature flag, a supply-undervoltage flag and the two active-low motor enables, all asynchronous, and synchronises them. From them it produces one global driver shutdown, a bridge enable for each motor, a request that returns each step indexer to its home position, a sleep indication that the clocking and charge-pump logic use to stop, and two sticky fault status bits.

A current-limit condition shuts the drivers down only when it persists. Any flag must be seen for `OCP_HOLD` consecutive synchronised cycles, and the timer restarts whenever every flag is clear. Overcurrent and over-temperature shutdowns are latched and clear only when the power-on reset (`rst_n`) is applied. Undervoltage is not latched: it forces shutdown and homes both indexers only while it lasts. When both motor enables are high the block enters sleep. In sleep it homes both indexers, turns all bridges off and ignores the current-limit and temperature inputs.

Top module: `fault_sleep_supervisor`

## Requirements
- R1: After `rst_n` is released with all faults clear and both enables low, `drv_off`=0, `bridge_en`=2'b11, `sleep`=0, `idx_home_req`=2'b00, and both latched status bits are 0.
- R2: If any bit of `ilim_flag` is high for `OCP_HOLD` consecutive synchronised cycles, `ocp_latched` becomes 1 and `drv_off`=1 with `bridge_en`=2'b00. The latch sets `SYNC_STAGES`+`OCP_HOLD` clock edges after the input rises.
- R3: A current-limit burst shorter than `OCP_HOLD` synchronised cycles never latches. A single cycle with all flags clear restarts the persistence count.
- R4: Once set, `ocp_latched` and the shutdown remain after the flags clear, until `rst_n` is applied.
- R5: A high `otemp_flag` sets `otp_latched` and shuts the drivers down `SYNC_STAGES`+1 edges after the input rises. The latch holds after the temperature recovers and clears only on `rst_n`.
- R6: While `uvlo_flag` is high, `drv_off`=1 and `idx_home_req`=2'b11. Both return to normal once it clears, with no latched status.
- R7: When both `motor_en_n` bits are high, `sleep`=1, `drv_off`=1, `bridge_en`=2'b00 and `idx_home_req`=2'b11. Sleep ends when either enable returns low.
- R8: While in sleep, `ilim_flag` and `otemp_flag` have no effect: no latch sets and the persistence count is cleared.
- R9: With exactly one `motor_en_n` bit high, only that motor's `bridge_en` bit is 0, and `sleep` stays 0.
- R10: Every asynchronous input passes through a `SYNC_STAGES`-flop synchroniser. A change on `motor_en_n` reaches `bridge_en` after exactly `SYNC_STAGES` clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Synchronous active-low power-on reset; the only way to clear latched faults |
| ilim_flag | input | NUM_FET | Asynchronous analog current-limit flags, one per output transistor |
| otemp_flag | input | 1 | Asynchronous over-temperature flag |
| uvlo_flag | input | 1 | Asynchronous supply-undervoltage flag |
| motor_en_n | input | 2 | Asynchronous active-low enable for each motor |
| drv_off | output | 1 | Global shutdown of all bridges |
| bridge_en | output | 2 | Per-motor bridge enable |
| idx_home_req | output | 2 | Per-motor request to return the step indexer to home |
| sleep | output | 1 | Sleep indication that stops the charge pump and clocks |
| ocp_latched | output | 1 | Sticky overcurrent shutdown status |
| otp_latched | output | 1 | Sticky over-temperature shutdown status |

## Verification
The bound checker watches on every cycle that the fault latches never drop outside reset, that any latched fault or sleep holds all bridges off, and that sleep always homes both indexers. It also checks that no latch can set while sleep holds, and that an overcurrent latch rises only after a synchronised current-limit flag. The exact edge on which each latch sets, the rejection of short or interrupted bursts, and recovery from undervoltage need the bench's directed scenarios. The same holds for the per-motor enable mapping and the synchroniser delay, since these depend on input history that a one-cycle property cannot count.

// File: rtl/fsup_pkg.sv
// Package: shared constants and types for the fault and sleep supervisor.
// Assumes exactly two motors, each with its own active-low enable.
package fsup_pkg;
    localparam int MOTORS = 2;

    // Fault state used to form the global shutdown.
    typedef struct packed {
        logic ocp;
        logic otp;
        logic uv;
    } fault_state_t;
endpackage

// File: rtl/fsup_sync.sv
// Module: multi-bit, multi-stage flop synchroniser.
// Assumes every bit is an independent level signal; no bus coherence is implied.
module fsup_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: shift the level one flop further along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '0;
                else if (s == 0) chain[s] <= d;
                else chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/fsup_persist_latch.sv
// Module: persistence-qualified sticky fault latch.
// Sets after `trip` is sampled high on HOLD consecutive edges while `gate`
// is low; a clear cycle or an active gate restarts the count. Once set it
// holds until the synchronous reset. Assumes HOLD >= 1.
module fsup_persist_latch #(
    parameter int HOLD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trip,
    input  logic gate,
    output logic latched
);
    localparam int CNT_W = (HOLD < 2) ? 1 : $clog2(HOLD);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD - 1);

    logic [CNT_W-1:0] cnt;

    // Purpose: count consecutive trip cycles and set the sticky latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            latched <= 1'b0;
        end else if (!latched) begin
            if (gate || !trip) begin
                cnt <= '0;
            end else if (cnt == LAST) begin
                latched <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fault_sleep_supervisor.sv
// Module: top of the supervisor. It synchronises the fault and enable
// inputs, qualifies overcurrent by persistence, latches overcurrent and
// over-temperature until power-on reset, and decodes sleep, shutdown and
// indexer homing. Assumes rst_n models the removal and return of motor supply.
module fault_sleep_supervisor #(
    parameter int NUM_FET     = 16,
    parameter int OCP_HOLD    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_FET-1:0] ilim_flag,
    input  logic               otemp_flag,
    input  logic               uvlo_flag,
    input  logic [1:0]         motor_en_n,
    output logic               drv_off,
    output logic [1:0]         bridge_en,
    output logic [1:0]         idx_home_req,
    output logic               sleep,
    output logic               ocp_latched,
    output logic               otp_latched
);
    import fsup_pkg::*;

    localparam int SYNC_W = NUM_FET + 2 + MOTORS;

    logic [SYNC_W-1:0]  raw_in, sync_out;
    logic [NUM_FET-1:0] ilim_s;
    logic               otemp_s, uv_s;
    logic [MOTORS-1:0]  en_n_s;
    logic               ilim_any_s;
    fault_state_t       fstate;

    assign raw_in = {motor_en_n, uvlo_flag, otemp_flag, ilim_flag};

    fsup_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
    );

    assign ilim_s     = sync_out[NUM_FET-1:0];
    assign otemp_s    = sync_out[NUM_FET];
    assign uv_s       = sync_out[NUM_FET+1];
    assign en_n_s     = sync_out[SYNC_W-1 -: MOTORS];
    assign ilim_any_s = |ilim_s;

    // Sleep holds only while every motor enable is inactive.
    assign sleep = &en_n_s;

    fsup_persist_latch #(.HOLD(OCP_HOLD)) u_ocp (
        .clk(clk), .rst_n(rst_n), .trip(ilim_any_s), .gate(sleep),
        .latched(ocp_latched)
    );

    fsup_persist_latch #(.HOLD(1)) u_otp (
        .clk(clk), .rst_n(rst_n), .trip(otemp_s), .gate(sleep),
        .latched(otp_latched)
    );

    assign fstate = '{ocp: ocp_latched, otp: otp_latched, uv: uv_s};

    // Purpose: decode global shutdown, per-motor enables and homing.
    always_comb begin
        drv_off = (|fstate) | sleep;
        for (int m = 0; m < MOTORS; m++) begin
            bridge_en[m]    = !drv_off && !en_n_s[m];
            idx_home_req[m] = sleep | uv_s;
        end
    end
endmodule

// Checker: cycle-level properties of the supervisor outputs.
module fsup_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       drv_off,
    input logic [1:0] bridge_en,
    input logic [1:0] idx_home_req,
    input logic       sleep,
    input logic       ocp_latched,
    input logic       otp_latched,
    input logic       ilim_any_s
);
    assert_ocp_after_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ocp_latched) |-> $past(ilim_any_s));

    assert_fault_shutdown_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ocp_latched || otp_latched) |-> (drv_off && bridge_en == 2'b00));

    assert_ocp_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ocp_latched |=> ocp_latched);

    assert_otp_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        otp_latched |=> otp_latched);

    assert_sleep_homes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (idx_home_req == 2'b11 && bridge_en == 2'b00));

    assert_sleep_no_ocp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && !ocp_latched) |=> !ocp_latched);

    assert_sleep_no_otp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && !otp_latched) |=> !otp_latched);
endmodule

bind fault_sleep_supervisor fsup_checker u_chk (
    .clk(clk), .rst_n(rst_n), .drv_off(drv_off), .bridge_en(bridge_en),
    .idx_home_req(idx_home_req), .sleep(sleep), .ocp_latched(ocp_latched),
    .otp_latched(otp_latched), .ilim_any_s(ilim_any_s)
);

// File: tb/tb_fault_sleep_supervisor.sv
module tb_fault_sleep_supervisor;
    localparam int NF   = 16;
    localparam int HOLD = 16;
    localparam int SYN  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NF-1:0] ilim_flag = '0;
    logic          otemp_flag = 1'b0;
    logic          uvlo_flag = 1'b0;
    logic [1:0]    motor_en_n = 2'b00;
    logic          drv_off, sleep, ocp_latched, otp_latched;
    logic [1:0]    bridge_en, idx_home_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fault_sleep_supervisor #(.NUM_FET(NF), .OCP_HOLD(HOLD), .SYNC_STAGES(SYN)) dut (
        .clk(clk), .rst_n(rst_n), .ilim_flag(ilim_flag), .otemp_flag(otemp_flag),
        .uvlo_flag(uvlo_flag), .motor_en_n(motor_en_n), .drv_off(drv_off),
        .bridge_en(bridge_en), .idx_home_req(idx_home_req), .sleep(sleep),
        .ocp_latched(ocp_latched), .otp_latched(otp_latched)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Packs outputs: {drv_off, sleep, ocp, otp, bridge_en, idx_home_req}
    function automatic logic [7:0] outs();
        return {drv_off, sleep, ocp_latched, otp_latched, bridge_en, idx_home_req};
    endfunction

    task automatic do_reset();
        ilim_flag = '0; otemp_flag = 1'b0; uvlo_flag = 1'b0; motor_en_n = 2'b00;
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(SYN + 1);
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R1 idle outputs", outs(), 8'b0000_1100);
    endtask

    task automatic t_ocp_exact();
        do_reset();
        ilim_flag[7] = 1'b1;
        tick(SYN + HOLD - 1);
        check("R2 not yet latched", {7'd0, ocp_latched}, 8'd0);
        tick(1);
        check("R2 latched on time", {7'd0, ocp_latched}, 8'd1);
        check("R2 shutdown", {5'd0, drv_off, bridge_en}, 8'b100);
        ilim_flag = '0;
        tick(HOLD);
        check("R4 ocp sticky", {5'd0, ocp_latched, bridge_en}, 8'b100);
        do_reset();
        check("R4 cleared by reset", outs(), 8'b0000_1100);
    endtask

    task automatic t_ocp_short();
        do_reset();
        ilim_flag[0] = 1'b1;
        tick(HOLD - 1);
        ilim_flag[0] = 1'b0;
        tick(1);
        ilim_flag[NF-1] = 1'b1;
        tick(HOLD - 1);
        ilim_flag = '0;
        tick(SYN + 3);
        check("R3 interrupted bursts ignored", {6'd0, ocp_latched, drv_off}, 8'd0);
        ilim_flag[3] = 1'b1;
        tick(HOLD - 1);
        ilim_flag = '0;
        tick(SYN + 3);
        check("R3 short burst ignored", {6'd0, ocp_latched, drv_off}, 8'd0);
    endtask

    task automatic t_otp();
        do_reset();
        otemp_flag = 1'b1;
        tick(SYN);
        check("R5 otp not yet", {7'd0, otp_latched}, 8'd0);
        tick(1);
        check("R5 otp latched", {6'd0, otp_latched, drv_off}, 8'b11);
        otemp_flag = 1'b0;
        tick(SYN + 4);
        check("R5 otp sticky", {5'd0, otp_latched, bridge_en}, 8'b100);
        do_reset();
        check("R5 cleared by reset", {7'd0, otp_latched}, 8'd0);
    endtask

    task automatic t_uvlo();
        do_reset();
        uvlo_flag = 1'b1;
        tick(SYN);
        check("R6 uv shutdown", outs(), 8'b1000_0011);
        uvlo_flag = 1'b0;
        tick(SYN);
        check("R6 uv recovery", outs(), 8'b0000_1100);
    endtask

    task automatic t_sleep();
        do_reset();
        motor_en_n = 2'b11;
        tick(SYN);
        check("R7 sleep entry", outs(), 8'b1100_0011);
        ilim_flag = '1;
        otemp_flag = 1'b1;
        tick(2 * HOLD);
        check("R8 no latch in sleep", {6'd0, ocp_latched, otp_latched}, 8'd0);
        ilim_flag = '0;
        otemp_flag = 1'b0;
        tick(SYN + 2);
        motor_en_n = 2'b10;
        tick(SYN);
        check("R7 sleep exit", outs(), 8'b0000_0100);
        tick(HOLD + 2);
        check("R8 still no latch", {6'd0, ocp_latched, otp_latched}, 8'd0);
    endtask

    task automatic t_per_motor();
        do_reset();
        motor_en_n = 2'b01;
        tick(SYN);
        check("R9 motor0 off only", outs(), 8'b0000_1000);
        motor_en_n = 2'b00;
        tick(SYN - 1);
        check("R10 sync delay not yet", {6'd0, bridge_en}, 8'b10);
        tick(1);
        check("R10 sync delay reached", {6'd0, bridge_en}, 8'b11);
    endtask

    initial begin
        t_reset_state();
        t_ocp_exact();
        t_ocp_short();
        t_otp();
        t_uvlo();
        t_sleep();
        t_per_motor();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule